// File: doc/BRIEF.md
# Power, Clock and Reset Control Register Bank

This block is the software-visible register file of a power, clock and reset manager. A 32-bit register bus reaches it through a single address. A write takes effect at the clock edge on which `bus_wr` is high. A read is combinational from `bus_addr`. The bank holds masked configuration registers, power-state control registers with bits forced to one, twenty scratch words, write-one-to-clear reset and wakeup status registers, and three interrupt targets. Each interrupt target has a status and enable pair that drives its own interrupt line.

Clock generation, PLLs and power sequencing sit outside the block. Hardware events reach the block as set pulses on status bits. Changes that the outside world must act on leave the block as one-cycle pulses: an analog-PLL update, a digital-PLL update and a system reset request.

Every write that is not accepted produces a one-cycle diagnostic pulse instead of a state change. This covers a write of the wrong size, a write to a read-only offset and a write to an undecoded offset. A write to a reserved PLL bit also produces a pulse, but its legal bits are still applied. All pulses are registered and are high for the cycle that follows the write edge.

Top module: `pcr_regbank`

## Requirements
- R1: A write with `bus_size` other than 2 (2 means a 32-bit word, 0 a byte, 1 a halfword) changes no register and pulses `err_width` for one cycle.
- R2: A word write to a read-only offset changes nothing and pulses `err_ro`. The read-only offsets are 0x000, 0x054, 0x084, 0x1e4, 0x220, 0x224, 0x22c, 0x2c8, 0x2e4, 0x320, 0x3e4, 0x420, 0x520, 0x820 and 0x8e4. Offset 0x000 reads the `REVISION` parameter (default 0x10), and the others read zero.
- R3: The interrupt status registers are at 0x018 (target 0), 0x8f0 (target 1) and 0x8f8 (target 2). Writing 1 to a status bit clears it. The enables are at 0x01c, 0x8f4 and 0x8fc and hold the low 6, 3 and 3 bits, with the upper bits reading zero.
- R4: Each interrupt line is high exactly when some status bit of its target is set together with its enable bit. The line follows a write to that target's status or enable register in the cycle after the write.
- R5: A status bit set by an event input in the same cycle as a clearing write to that bit stays set.
- R6: The reset-status registers (0x158, 0x358, 0x458, 0x858, each 8 bits wide) and the wakeup-status registers (0x2b0, 0x2b4, 0x4b0, each 32 bits wide) are set by their event inputs and cleared by writing 1.
- R7: The power-state registers apply the following masks and forced bits:
  - 0x1e0 keeps mask 0xc0f.
  - 0x2e0 keeps mask 0xfc3f and always has bit 2 set.
  - 0x3e0 keeps mask 0xc0f and always has bits 3:2 set.
  - 0x8e0 keeps mask 0x3017 and always has bits 3:2 set.
  - The forced bits are also the reset values.
- R8: A word write to 0x450 with bit 1 set raises `sys_rst_req` for exactly one cycle and changes no register.
- R9: The PLL enable register at 0x500 stores bits 7:6, 3:2 and 1:0. `apll_upd` pulses only when bits 7:6 or 3:2 change value.
- R10: `dpll_upd` pulses only when bits 1:0 of 0x500 change value, or when the 2-bit PLL select register at 0x544 changes value.
- R11: A write that sets any bit of 0x500 in mask 0xffffff30, or any bit 31:2 of 0x544, pulses `warn_rsvd`. The legal bits of that write are still stored.
- R12: The twenty scratch registers at 0x0b0 to 0x0fc (step 4) store and return all 32 bits.
- R13: A word write to any offset that is not decoded, including an offset with address bits 1:0 non-zero, changes nothing and pulses `err_addr`. That offset reads zero.
- R14: The configuration registers keep masked values and reset to zero: 0x010 keeps mask 0x1, 0x050 keeps mask 0xf1c3 and 0x060 keeps mask 0xdb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_evt_mpu | input | 6 | Event set pulses for interrupt target 0 |
| irq_evt_dsp | input | 3 | Event set pulses for interrupt target 1 |
| irq_evt_iva | input | 3 | Event set pulses for interrupt target 2 |
| rst_evt | input | 32 | Reset-status set pulses, 8 per domain, 4 domains |
| wake_evt | input | 96 | Wakeup-status set pulses, 32 per register, 3 registers |
| irq_mpu | output | 1 | Interrupt line of target 0 |
| irq_dsp | output | 1 | Interrupt line of target 1 |
| irq_iva | output | 1 | Interrupt line of target 2 |
| apll_upd | output | 1 | Analog-PLL enable group changed |
| dpll_upd | output | 1 | Digital-PLL enable or select changed |
| sys_rst_req | output | 1 | One-cycle system reset request |
| err_width | output | 1 | Wrong-size write pulse |
| err_ro | output | 1 | Write to a read-only offset pulse |
| err_addr | output | 1 | Write to an undecoded offset pulse |
| warn_rsvd | output | 1 | Reserved PLL bit written pulse |

## Verification
The masked registers are written with all ones and with all zeros. This separates a missing mask from a missing forced bit, and a scratch word of alternating bits shows that no bit is dropped. The PLL registers receive writes that change only the analog group, only the digital group, nothing at all, and only reserved bits. Each pulse must therefore fire on a real change and stay low otherwise. The interrupt tests set status bits under a full enable, a cleared enable and a partial enable. They then clear one bit while an event sets another in the same cycle, which tells a lost event apart from a clear that fails.

// File: rtl/pcr_pkg.sv
// Package pcr_pkg: offsets, masks and sizes shared by the register bank.
// Assumes 12-bit byte offsets and 32-bit word data.
package pcr_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // interrupt targets
    localparam int N_TGT     = 3;
    localparam int IRQ_WMAX  = 6;
    localparam int IRQ_EVT_W = 12;
    localparam int IRQ_W   [N_TGT] = '{6, 3, 3};
    localparam int IRQ_LSB [N_TGT] = '{0, 6, 9};
    localparam logic [ADDR_W-1:0] IRQ_ST_ADDR [N_TGT] = '{12'h018, 12'h8f0, 12'h8f8};
    localparam logic [ADDR_W-1:0] IRQ_EN_ADDR [N_TGT] = '{12'h01c, 12'h8f4, 12'h8fc};

    // masked registers: 0..2 configuration, 3..6 power-state control
    localparam int N_MREG = 7;
    localparam logic [ADDR_W-1:0] MREG_ADDR [N_MREG] =
        '{12'h010, 12'h050, 12'h060, 12'h1e0, 12'h2e0, 12'h3e0, 12'h8e0};
    localparam logic [DATA_W-1:0] MREG_MASK [N_MREG] =
        '{32'h1, 32'hf1c3, 32'hdb, 32'hc0f, 32'hfc3f, 32'hc0f, 32'h3017};
    localparam logic [DATA_W-1:0] MREG_FORCE [N_MREG] =
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h4, 32'hc, 32'hc};

    // write-one-to-clear status groups
    localparam int N_RST = 4;
    localparam logic [ADDR_W-1:0] RST_ADDR [N_RST] = '{12'h158, 12'h358, 12'h458, 12'h858};
    localparam int N_WK = 3;
    localparam logic [ADDR_W-1:0] WK_ADDR [N_WK] = '{12'h2b0, 12'h2b4, 12'h4b0};

    // read-only offsets
    localparam int N_RO = 15;
    localparam logic [ADDR_W-1:0] RO_ADDR [N_RO] =
        '{12'h000, 12'h054, 12'h084, 12'h1e4, 12'h220, 12'h224, 12'h22c, 12'h2c8,
          12'h2e4, 12'h320, 12'h3e4, 12'h420, 12'h520, 12'h820, 12'h8e4};

    // single registers
    localparam logic [ADDR_W-1:0] A_REV      = 12'h000;
    localparam logic [ADDR_W-1:0] A_RSTCTL   = 12'h450;
    localparam logic [ADDR_W-1:0] A_PLL_EN   = 12'h500;
    localparam logic [ADDR_W-1:0] A_PLL_SEL  = 12'h544;
    localparam logic [ADDR_W-1:0] A_SCR_BASE = 12'h0b0;

    localparam logic [7:0]        PLL_EN_KEEP  = 8'hcf;
    localparam logic [7:0]        PLL_APLL_GRP = 8'hcc;
    localparam logic [DATA_W-1:0] PLL_EN_RSVD  = 32'hffffff30;
endpackage

// File: rtl/pcr_w1c_reg.sv
// pcr_w1c_reg: status register whose bits are set by event pulses and
// cleared by writing one. Assumes an event outranks a clear of the same bit.
module pcr_w1c_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] evt,
    output logic [W-1:0] q
);
    // clear first, then merge events so that a same-cycle event survives
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clr_en) q <= (q & ~clr_mask) | evt;
        else             q <= q | evt;
    end
endmodule

// File: rtl/pcr_irq_target.sv
// pcr_irq_target: one interrupt target, i.e. a W-bit write-one-to-clear
// status register, a W-bit enable register and the interrupt line.
// Assumes the caller gates st_clr and en_wr with an accepted word write.
module pcr_irq_target #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         st_clr,
    input  logic         en_wr,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] evt,
    output logic [W-1:0] st,
    output logic [W-1:0] en,
    output logic         irq
);
    pcr_w1c_reg #(.W(W)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (st_clr),
        .clr_mask (wval),
        .evt      (evt),
        .q        (st)
    );

    // enable register, keeps only its W legal bits
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= wval;
    end

    // interrupt line from pending and enabled bits
    assign irq = |(st & en);
endmodule

// File: rtl/pcr_pll_ctl.sv
// pcr_pll_ctl: PLL enable and select registers. Update pulses are issued
// only when a bit group really changes value. Reserved-bit writes raise a
// warning pulse, and the legal bits are still stored.
// Assumes en_wr and sel_wr are never high together (distinct offsets).
module pcr_pll_ctl
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              sel_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        en_q,
    output logic [1:0]        sel_q,
    output logic              apll_pulse,
    output logic              dpll_pulse,
    output logic              warn_pulse
);
    logic apll_chg, dpll_chg, warn_d;

    // change and reserved-bit detection against the stored values
    always_comb begin
        apll_chg = en_wr && (((en_q ^ wdata[7:0]) & PLL_APLL_GRP) != 8'h0);
        dpll_chg = (en_wr && (en_q[1:0] != wdata[1:0])) ||
                   (sel_wr && (sel_q != wdata[1:0]));
        warn_d   = (en_wr && ((wdata & PLL_EN_RSVD) != '0)) ||
                   (sel_wr && (wdata[DATA_W-1:2] != '0));
    end

    // storage of the legal bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (en_wr)  en_q  <= wdata[7:0] & PLL_EN_KEEP;
            if (sel_wr) sel_q <= wdata[1:0];
        end
    end

    // registered one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apll_pulse <= 1'b0;
            dpll_pulse <= 1'b0;
            warn_pulse <= 1'b0;
        end else begin
            apll_pulse <= apll_chg;
            dpll_pulse <= dpll_chg;
            warn_pulse <= warn_d;
        end
    end
endmodule

// File: rtl/pcr_scratch.sv
// pcr_scratch: N general-purpose 32-bit words with one write port and one
// read port. Assumes wr_idx is in range whenever wr is high.
module pcr_scratch #(
    parameter int N     = 20,
    parameter int W     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] word [N];

    for (genvar i = 0; i < N; i++) begin : g_word
        // one storage word, written whole
        always_ff @(posedge clk) begin
            if (!rst_n)                      word[i] <= '0;
            else if (wr && wr_idx == IDX_W'(i)) word[i] <= wdata;
        end
    end

    // read selection, out-of-range index returns zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (rd_idx == IDX_W'(i)) rd_data = word[i];
    end
endmodule

// File: rtl/pcr_regbank.sv
// pcr_regbank: control and status register bank of a power, clock and reset
// manager. It decodes word writes, holds masked, forced, scratch and
// write-one-to-clear registers, drives three interrupt lines, and emits
// registered one-cycle update, reset-request and diagnostic pulses.
// Assumes writes take effect on the edge where bus_wr is high and that
// reads are combinational from bus_addr.
module pcr_regbank
    import pcr_pkg::*;
#(
    parameter logic [31:0] REVISION = 32'h0000_0010,
    parameter int          RST_W    = 8,
    parameter int          WK_W     = 32,
    parameter int          N_SCR    = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [1:0]             bus_size,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [5:0]             irq_evt_mpu,
    input  logic [2:0]             irq_evt_dsp,
    input  logic [2:0]             irq_evt_iva,
    input  logic [N_RST*RST_W-1:0] rst_evt,
    input  logic [N_WK*WK_W-1:0]   wake_evt,
    output logic                   irq_mpu,
    output logic                   irq_dsp,
    output logic                   irq_iva,
    output logic                   apll_upd,
    output logic                   dpll_upd,
    output logic                   sys_rst_req,
    output logic                   err_width,
    output logic                   err_ro,
    output logic                   err_addr,
    output logic                   warn_rsvd
);
    localparam int SCR_IDX_W = $clog2(N_SCR);
    localparam logic [ADDR_W-1:0] SCR_END = A_SCR_BASE + ADDR_W'(4 * N_SCR);

    // decode results
    logic                  wr_word;
    logic                  is_ro, known;
    logic [N_MREG-1:0]     mreg_hit;
    logic [N_TGT-1:0]      ist_hit, ien_hit;
    logic [N_RST-1:0]      rst_hit;
    logic [N_WK-1:0]       wk_hit;
    logic                  rstctl_hit, pll_en_hit, pll_sel_hit, scr_hit;
    logic [ADDR_W-1:0]     scr_off;
    logic [SCR_IDX_W-1:0]  scr_idx;

    // register state
    logic [DATA_W-1:0]     mreg_q [N_MREG];
    logic [IRQ_WMAX-1:0]   irq_st_pad [N_TGT];
    logic [IRQ_WMAX-1:0]   irq_en_pad [N_TGT];
    logic [N_TGT-1:0]      irq_vec;
    logic [IRQ_EVT_W-1:0]  irq_evt_all;
    logic [RST_W-1:0]      rst_q [N_RST];
    logic [WK_W-1:0]       wk_q [N_WK];
    logic [7:0]            pll_en_q;
    logic [1:0]            pll_sel_q;
    logic [DATA_W-1:0]     scr_rd;
    logic [IRQ_WMAX-1:0]   mpu_st, mpu_en;

    // address decode, independent of the write strobe
    always_comb begin
        wr_word     = bus_wr && (bus_size == SZ_WORD);
        is_ro       = 1'b0;
        for (int i = 0; i < N_RO; i++)
            if (bus_addr == RO_ADDR[i]) is_ro = 1'b1;
        for (int i = 0; i < N_MREG; i++) mreg_hit[i] = (bus_addr == MREG_ADDR[i]);
        for (int i = 0; i < N_TGT; i++) begin
            ist_hit[i] = (bus_addr == IRQ_ST_ADDR[i]);
            ien_hit[i] = (bus_addr == IRQ_EN_ADDR[i]);
        end
        for (int i = 0; i < N_RST; i++) rst_hit[i] = (bus_addr == RST_ADDR[i]);
        for (int i = 0; i < N_WK; i++)  wk_hit[i]  = (bus_addr == WK_ADDR[i]);
        rstctl_hit  = (bus_addr == A_RSTCTL);
        pll_en_hit  = (bus_addr == A_PLL_EN);
        pll_sel_hit = (bus_addr == A_PLL_SEL);
        scr_hit     = (bus_addr >= A_SCR_BASE) && (bus_addr < SCR_END) &&
                      (bus_addr[1:0] == 2'b00);
        scr_off     = bus_addr - A_SCR_BASE;
        scr_idx     = scr_off[SCR_IDX_W+1:2];
        known       = (|mreg_hit) || (|ist_hit) || (|ien_hit) || (|rst_hit) ||
                      (|wk_hit) || rstctl_hit || pll_en_hit || pll_sel_hit || scr_hit;
    end

    // masked and forced-one registers
    for (genvar i = 0; i < N_MREG; i++) begin : g_mreg
        // keep legal bits, force the fixed-one bits
        always_ff @(posedge clk) begin
            if (!rst_n)
                mreg_q[i] <= MREG_FORCE[i];
            else if (wr_word && mreg_hit[i])
                mreg_q[i] <= (bus_wdata & MREG_MASK[i]) | MREG_FORCE[i];
        end
    end

    // interrupt targets
    assign irq_evt_all = {irq_evt_iva, irq_evt_dsp, irq_evt_mpu};

    for (genvar g = 0; g < N_TGT; g++) begin : g_irq
        localparam int TW = IRQ_W[g];
        logic [TW-1:0] st, en;
        pcr_irq_target #(.W(TW)) u_tgt (
            .clk    (clk),
            .rst_n  (rst_n),
            .st_clr (wr_word && ist_hit[g]),
            .en_wr  (wr_word && ien_hit[g]),
            .wval   (bus_wdata[TW-1:0]),
            .evt    (irq_evt_all[IRQ_LSB[g] +: TW]),
            .st     (st),
            .en     (en),
            .irq    (irq_vec[g])
        );
        assign irq_st_pad[g] = IRQ_WMAX'(st);
        assign irq_en_pad[g] = IRQ_WMAX'(en);
    end

    assign irq_mpu = irq_vec[0];
    assign irq_dsp = irq_vec[1];
    assign irq_iva = irq_vec[2];
    assign mpu_st  = irq_st_pad[0];
    assign mpu_en  = irq_en_pad[0];

    // reset-status registers
    for (genvar i = 0; i < N_RST; i++) begin : g_rst
        pcr_w1c_reg #(.W(RST_W)) u_rst (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_en   (wr_word && rst_hit[i]),
            .clr_mask (bus_wdata[RST_W-1:0]),
            .evt      (rst_evt[i*RST_W +: RST_W]),
            .q        (rst_q[i])
        );
    end

    // wakeup-status registers
    for (genvar i = 0; i < N_WK; i++) begin : g_wk
        pcr_w1c_reg #(.W(WK_W)) u_wk (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_en   (wr_word && wk_hit[i]),
            .clr_mask (bus_wdata[WK_W-1:0]),
            .evt      (wake_evt[i*WK_W +: WK_W]),
            .q        (wk_q[i])
        );
    end

    pcr_pll_ctl u_pll (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (wr_word && pll_en_hit),
        .sel_wr     (wr_word && pll_sel_hit),
        .wdata      (bus_wdata),
        .en_q       (pll_en_q),
        .sel_q      (pll_sel_q),
        .apll_pulse (apll_upd),
        .dpll_pulse (dpll_upd),
        .warn_pulse (warn_rsvd)
    );

    pcr_scratch #(.N(N_SCR), .W(DATA_W)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_word && scr_hit),
        .wr_idx  (scr_idx),
        .wdata   (bus_wdata),
        .rd_idx  (scr_idx),
        .rd_data (scr_rd)
    );

    // diagnostic and reset-request pulses, registered for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_width   <= 1'b0;
            err_ro      <= 1'b0;
            err_addr    <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            err_width   <= bus_wr && (bus_size != SZ_WORD);
            err_ro      <= wr_word && is_ro;
            err_addr    <= wr_word && !is_ro && !known;
            sys_rst_req <= wr_word && rstctl_hit && bus_wdata[1];
        end
    end

    // read multiplexer, undecoded offsets read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_REV) bus_rdata = REVISION;
        for (int i = 0; i < N_MREG; i++)
            if (mreg_hit[i]) bus_rdata = mreg_q[i];
        for (int i = 0; i < N_TGT; i++) begin
            if (ist_hit[i]) bus_rdata = DATA_W'(irq_st_pad[i]);
            if (ien_hit[i]) bus_rdata = DATA_W'(irq_en_pad[i]);
        end
        for (int i = 0; i < N_RST; i++)
            if (rst_hit[i]) bus_rdata = DATA_W'(rst_q[i]);
        for (int i = 0; i < N_WK; i++)
            if (wk_hit[i]) bus_rdata = DATA_W'(wk_q[i]);
        if (pll_en_hit)  bus_rdata = DATA_W'(pll_en_q);
        if (pll_sel_hit) bus_rdata = DATA_W'(pll_sel_q);
        if (scr_hit)     bus_rdata = scr_rd;
    end
endmodule

// File: rtl/pcr_regbank_chk.sv
// pcr_regbank_chk: temporal checks on the register bank, bound to every
// pcr_regbank instance. Assumes reset is held for at least two cycles.
module pcr_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_size,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [5:0]  irq_evt_mpu,
    input logic [5:0]  mpu_st,
    input logic [7:0]  pll_en_q,
    input logic [1:0]  pll_sel_q,
    input logic        apll_upd,
    input logic        dpll_upd,
    input logic        sys_rst_req,
    input logic        err_width,
    input logic        err_ro,
    input logic        err_addr
);
    p_width_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != 2'd2) |=> err_width);

    p_width_keeps_pll_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != 2'd2) |=> ($stable(pll_en_q) && $stable(pll_sel_q)));

    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt_mpu != 6'd0) |=> ((mpu_st & $past(irq_evt_mpu)) == $past(irq_evt_mpu)));

    p_core_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h2e0) |-> bus_rdata[2]);

    p_rst_req_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(bus_wr && bus_size == 2'd2 && bus_addr == 12'h450 && bus_wdata[1]));

    p_apll_real_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        apll_upd |-> ((pll_en_q & 8'hcc) != $past(pll_en_q & 8'hcc)));

    p_apll_no_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pll_en_q & 8'hcc) != $past(pll_en_q & 8'hcc)) |-> apll_upd);

    p_dpll_real_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dpll_upd |-> ({pll_en_q[1:0], pll_sel_q} != $past({pll_en_q[1:0], pll_sel_q})));

    p_single_error_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_width, err_ro, err_addr}));
endmodule

bind pcr_regbank pcr_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_evt_mpu (irq_evt_mpu),
    .mpu_st      (mpu_st),
    .pll_en_q    (pll_en_q),
    .pll_sel_q   (pll_sel_q),
    .apll_upd    (apll_upd),
    .dpll_upd    (dpll_upd),
    .sys_rst_req (sys_rst_req),
    .err_width   (err_width),
    .err_ro      (err_ro),
    .err_addr    (err_addr)
);

// File: tb/pcr_regbank_tb.sv
// pcr_regbank_tb: vector table of write and read-back pairs, then directed
// tests for reset, pulses, interrupts and error cases.
module pcr_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq_evt_mpu = '0;
    logic [2:0]  irq_evt_dsp = '0;
    logic [2:0]  irq_evt_iva = '0;
    logic [31:0] rst_evt = '0;
    logic [95:0] wake_evt = '0;
    logic irq_mpu, irq_dsp, irq_iva, apll_upd, dpll_upd, sys_rst_req;
    logic err_width, err_ro, err_addr, warn_rsvd;

    int n_chk = 0;
    int n_fail = 0;
    logic f_w, f_ro, f_ad, f_warn, f_ap, f_dp, f_rr;
    logic [31:0] rv;

    always #10 clk = ~clk;

    pcr_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_evt_mpu(irq_evt_mpu), .irq_evt_dsp(irq_evt_dsp), .irq_evt_iva(irq_evt_iva),
        .rst_evt(rst_evt), .wake_evt(wake_evt),
        .irq_mpu(irq_mpu), .irq_dsp(irq_dsp), .irq_iva(irq_iva),
        .apll_upd(apll_upd), .dpll_upd(dpll_upd), .sys_rst_req(sys_rst_req),
        .err_width(err_width), .err_ro(err_ro), .err_addr(err_addr), .warn_rsvd(warn_rsvd)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int N_VEC = 13;
    localparam vec_t VECS [N_VEC] = '{
        '{12'h010, 32'hffffffff, 32'h00000001, 8'd14},  // R14 config mask
        '{12'h050, 32'hffffffff, 32'h0000f1c3, 8'd14},  // R14
        '{12'h060, 32'hffffffff, 32'h000000db, 8'd14},  // R14
        '{12'h2e0, 32'h00000000, 32'h00000004, 8'd7},   // R7 forced bit 2
        '{12'h2e0, 32'hffffffff, 32'h0000fc3f, 8'd7},   // R7
        '{12'h3e0, 32'h00000000, 32'h0000000c, 8'd7},   // R7 forced bits 3:2
        '{12'h8e0, 32'hffffffff, 32'h0000301f, 8'd7},   // R7
        '{12'h1e0, 32'hffffffff, 32'h00000c0f, 8'd7},   // R7
        '{12'h0b0, 32'hdeadbeef, 32'hdeadbeef, 8'd12},  // R12 scratch first
        '{12'h0fc, 32'h5a5aa5a5, 32'h5a5aa5a5, 8'd12},  // R12 scratch last
        '{12'h01c, 32'hffffffff, 32'h0000003f, 8'd3},   // R3 enable width 6
        '{12'h8f4, 32'hffffffff, 32'h00000007, 8'd3},   // R3 enable width 3
        '{12'h8fc, 32'h00000005, 32'h00000005, 8'd3}    // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one write cycle; afterwards the registered pulses of that write are visible
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'd2;
        f_w = err_width; f_ro = err_ro; f_ad = err_addr; f_warn = warn_rsvd;
        f_ap = apll_upd; f_dp = dpll_upd; f_rr = sys_rst_req;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R7, R14)
        rd(12'h2e0, rv); chk("R7 reset core power", rv, 32'h4);
        rd(12'h3e0, rv); chk("R7 reset gfx power", rv, 32'hc);
        rd(12'h010, rv); chk("R14 reset config", rv, 32'h0);
        chk("R4 reset irq lines", {29'b0, irq_mpu, irq_dsp, irq_iva}, 32'h0);
        chk("R13 reset flags", {28'b0, err_width, err_ro, err_addr, warn_rsvd}, 32'h0);

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            wr(VECS[i].addr, VECS[i].data, 2'd2);
            rd(VECS[i].addr, rv);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), rv, VECS[i].exp);
        end

        // R1 wrong size writes
        wr(12'h0b0, 32'h0, 2'd1);
        chk("R1 width flag", {31'b0, f_w}, 32'h1);
        chk("R1 no addr flag", {31'b0, f_ad}, 32'h0);
        rd(12'h0b0, rv); chk("R1 scratch kept", rv, 32'hdeadbeef);
        wr(12'h500, 32'hff, 2'd0);
        chk("R1 no pll pulse", {30'b0, f_ap, f_dp}, 32'h0);
        rd(12'h500, rv); chk("R1 pll kept", rv, 32'h0);

        // R2 read-only offsets
        wr(12'h000, 32'hffffffff, 2'd2);
        chk("R2 ro flag", {31'b0, f_ro}, 32'h1);
        rd(12'h000, rv); chk("R2 revision", rv, 32'h10);
        wr(12'h2e4, 32'hffffffff, 2'd2);
        chk("R2 ro flag only", {30'b0, f_ro, f_ad}, 32'h2);
        rd(12'h2e4, rv); chk("R2 ro reads zero", rv, 32'h0);

        // R13 undecoded offsets
        wr(12'h0b2, 32'h1234, 2'd2);
        chk("R13 misaligned", {31'b0, f_ad}, 32'h1);
        rd(12'h0b0, rv); chk("R13 scratch untouched", rv, 32'hdeadbeef);
        wr(12'h100, 32'h1234, 2'd2);
        chk("R13 past scratch", {31'b0, f_ad}, 32'h1);
        rd(12'h100, rv); chk("R13 reads zero", rv, 32'h0);

        // R3 and R4 interrupt status, clear and enable
        @(negedge clk); irq_evt_mpu = 6'b000101;
        @(negedge clk); irq_evt_mpu = 6'b0;
        chk("R4 mpu line set", {31'b0, irq_mpu}, 32'h1);
        rd(12'h018, rv); chk("R3 mpu status", rv, 32'h5);
        wr(12'h018, 32'h1, 2'd2);
        rd(12'h018, rv); chk("R3 w1c one bit", rv, 32'h4);
        chk("R4 still pending", {31'b0, irq_mpu}, 32'h1);
        wr(12'h01c, 32'h0, 2'd2);
        chk("R4 masked off", {31'b0, irq_mpu}, 32'h0);
        rd(12'h018, rv); chk("R4 status kept", rv, 32'h4);

        // R5 event beats clear in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h0c; irq_evt_mpu = 6'b001000;
        @(negedge clk);
        bus_wr = 1'b0; irq_evt_mpu = 6'b0;
        rd(12'h018, rv); chk("R5 event wins", rv, 32'h8);

        // R4 other targets, partial enable on target 2
        @(negedge clk); irq_evt_dsp = 3'b010; irq_evt_iva = 3'b010;
        @(negedge clk); irq_evt_dsp = 3'b0;   irq_evt_iva = 3'b0;
        chk("R4 dsp line", {31'b0, irq_dsp}, 32'h1);
        chk("R4 iva masked bit", {31'b0, irq_iva}, 32'h0);
        @(negedge clk); irq_evt_iva = 3'b100;
        @(negedge clk); irq_evt_iva = 3'b0;
        chk("R4 iva enabled bit", {31'b0, irq_iva}, 32'h1);
        wr(12'h8f8, 32'h7, 2'd2);
        chk("R4 iva cleared", {31'b0, irq_iva}, 32'h0);

        // R6 reset and wakeup status
        @(negedge clk); rst_evt[8] = 1'b1;
        @(negedge clk); rst_evt[8] = 1'b0;
        rd(12'h358, rv); chk("R6 reset status set", rv, 32'h1);
        wr(12'h358, 32'h1, 2'd2);
        rd(12'h358, rv); chk("R6 reset status clear", rv, 32'h0);
        @(negedge clk); wake_evt[67] = 1'b1;
        @(negedge clk); wake_evt[67] = 1'b0;
        rd(12'h4b0, rv); chk("R6 wake status set", rv, 32'h8);
        wr(12'h4b0, 32'h0, 2'd2);
        rd(12'h4b0, rv); chk("R6 zero write keeps", rv, 32'h8);
        wr(12'h4b0, 32'h8, 2'd2);
        rd(12'h4b0, rv); chk("R6 wake status clear", rv, 32'h0);

        // R8 system reset request
        wr(12'h450, 32'h2, 2'd2);
        chk("R8 request pulse", {31'b0, f_rr}, 32'h1);
        @(negedge clk);
        chk("R8 one cycle", {31'b0, sys_rst_req}, 32'h0);
        rd(12'h2e0, rv); chk("R8 no state change", rv, 32'h0000fc3f);
        wr(12'h450, 32'h1, 2'd2);
        chk("R8 bit0 no request", {31'b0, f_rr}, 32'h0);

        // R9 analog group pulses
        wr(12'h500, 32'h0c, 2'd2);
        chk("R9 apll on change", {30'b0, f_ap, f_dp}, 32'h2);
        rd(12'h500, rv); chk("R9 stored", rv, 32'h0c);
        wr(12'h500, 32'h0c, 2'd2);
        chk("R9 no pulse same value", {30'b0, f_ap, f_dp}, 32'h0);

        // R10 digital group and select pulses
        wr(12'h500, 32'h0d, 2'd2);
        chk("R10 dpll on enable change", {30'b0, f_ap, f_dp}, 32'h1);
        wr(12'h544, 32'h2, 2'd2);
        chk("R10 dpll on select change", {31'b0, f_dp}, 32'h1);
        wr(12'h544, 32'h2, 2'd2);
        chk("R10 select same value", {31'b0, f_dp}, 32'h0);
        rd(12'h544, rv); chk("R10 select stored", rv, 32'h2);

        // R11 reserved bits warn, legal bits applied
        wr(12'h500, 32'h3d, 2'd2);
        chk("R11 enable warn", {29'b0, f_warn, f_ap, f_dp}, 32'h4);
        rd(12'h500, rv); chk("R11 legal bits kept", rv, 32'h0d);
        wr(12'h544, 32'h6, 2'd2);
        chk("R11 select warn", {30'b0, f_warn, f_dp}, 32'h2);
        rd(12'h544, rv); chk("R11 select legal bits", rv, 32'h2);
        wr(12'h500, 32'hc0, 2'd2);
        chk("R11 clean write no warn", {29'b0, f_warn, f_ap, f_dp}, 32'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule